// File: doc/BRIEF.md
# Serial Programming Target Port

This block is the device-side receiver of an in-system serial programming port. It runs on the device's CPU clock. It oversamples the serial clock, the serial data input and the programming reset pin through synchronisers, then assembles 32-bit instructions. Each instruction is four bytes, shifted most significant bit first.

Each complete instruction is presented as a one-cycle strobe carrying the opcode, a 16-bit address field and a data byte. A page-load instruction also produces a write into an external page buffer, at the slot taken from the low address bits. The block returns bytes on its serial output:
- the second byte of a prefix instruction is echoed while the third byte is shifting in;
- for read instructions, a memory byte is returned during the fourth byte.

A programming-enable instruction must be accepted before any other instruction has an effect. Framing is recovered only by a high pulse on the programming reset pin.

Top module: `prog_serial_target`

## Requirements
- R1: While `rstN` is low, `sdoPin`, `progEnabled`, `instrValid` and `pageWrEn` are all 0.
- R2: After the 32nd rising edge of `sckPin`, bits are taken MSB first. If the instruction is accepted, `instrValid` pulses for one cycle with `instrOpcode` = byte 1, `instrAddr` = {byte 2, byte 3} and `instrData` = byte 4.
- R3: When byte 1 is 0xAC, byte 2 is driven back on `sdoPin`, MSB first, during byte 3. It changes only after falling edges of `sckPin`, whatever byte 2 was.
- R4: The instruction 0xAC 0x53 xx xx sets `progEnabled` and is strobed on `instrValid` even when the block is not yet enabled.
- R5: While `progEnabled` is 0, no other instruction pulses `instrValid` or `pageWrEn`, and `sdoPin` stays 0 for reads.
- R6: When enabled, opcode 0x40 (low byte) or 0x48 (high byte) pulses `pageWrEn` together with `instrValid`. `pageSlot` = byte 3 bits [6:0], `pageHigh` = opcode bit 3, and the byte to store is `instrData`.
- R7: When enabled, opcodes 0x20, 0x28 and 0xA0 are reads. `rdAddr` shows {byte 2, byte 3} once byte 3 is in, and `readData` is returned on `sdoPin`, MSB first, during byte 4.
- R8: `sdoPin` is 0 whenever no echo or read byte is being returned.
- R9: A high pulse on `progResetPin` returns the bit counter to zero and clears `progEnabled`. This is the only way to recover from a stream that is offset by a few bits.
- R10: If the synchronised reset pin and the final rising edge of an instruction arrive in the same cycle, the reset wins: no strobe is produced and `progEnabled` is cleared.
- R11: When enabled, the chip-erase instruction 0xAC 0x80 xx xx is strobed and leaves `progEnabled` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| sckPin | input | 1 | Serial clock from programmer (asynchronous) |
| sdiPin | input | 1 | Serial data in (asynchronous) |
| progResetPin | input | 1 | Programming reset, active high (asynchronous) |
| readData | input | 8 | Memory byte at `rdAddr`, returned by read instructions |
| sdoPin | output | 1 | Serial data out |
| progEnabled | output | 1 | Programming-enable instruction accepted |
| instrValid | output | 1 | One-cycle decoded-instruction strobe |
| instrOpcode | output | 8 | Byte 1 of the strobed instruction |
| instrAddr | output | 16 | Bytes 2 and 3 of the strobed instruction |
| instrData | output | 8 | Byte 4 of the strobed instruction |
| rdAddr | output | 16 | Address field of the instruction in progress |
| pageWrEn | output | 1 | Page buffer write strobe |
| pageSlot | output | 7 | Page buffer slot |
| pageHigh | output | 1 | High-byte select for the page write |

## Verification
The programming reset and the 32nd serial clock rise pass through synchronisers of equal depth, so both can reach the logic in the same CPU cycle. The bench provokes this by raising `sckPin` and `progResetPin` on the same clock edge at the end of an otherwise valid page-load. It then judges that the scoreboard receives no strobe and no page write, and that `progEnabled` reads 0. A fresh enable instruction must then be accepted with correct framing.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int INSTR_BITS = 32;
  localparam logic [7:0] OP_PREFIX  = 8'hAC;
  localparam logic [7:0] KEY_ENABLE = 8'h53;
  localparam logic [7:0] OP_LOAD_LO = 8'h40;
  localparam logic [7:0] OP_LOAD_HI = 8'h48;
  localparam logic [7:0] OP_RD_LO   = 8'h20;
  localparam logic [7:0] OP_RD_HI   = 8'h28;
  localparam logic [7:0] OP_RD_EE   = 8'hA0;

  typedef struct packed {
    logic       txLoad;
    logic [7:0] txByte;
  } ctrlStrobes_t;

  function automatic logic isReadOp(input logic [7:0] op);
    return (op == OP_RD_LO) || (op == OP_RD_HI) || (op == OP_RD_EE);
  endfunction
endpackage

// File: rtl/isp_datapath.sv
module isp_datapath
  import isp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sckPin,
  input  logic                  sdiPin,
  input  logic                  progResetPin,
  input  ctrlStrobes_t          ctrl,
  output logic                  sdo,
  output logic                  rstSync,
  output logic                  byteDone,
  output logic [1:0]            byteIdx,
  output logic [INSTR_BITS-1:0] rxWord
);
  localparam int CW = $clog2(INSTR_BITS);

  logic [SYNC_STAGES-1:0][2:0] stage;
  logic [2:0] pinVec, syncVec;
  logic sckS, sdiS, sckPrev, rise, fall;
  logic [CW-1:0] bitCnt;
  logic [7:0] txShift;

  assign pinVec  = {progResetPin, sdiPin, sckPin};
  assign syncVec = stage[SYNC_STAGES-1];
  assign sckS    = syncVec[0];
  assign sdiS    = syncVec[1];
  assign rstSync = syncVec[2];
  assign rise    = sckS & ~sckPrev;
  assign fall    = ~sckS & sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage   <= '0;
      sckPrev <= 1'b0;
    end else begin
      stage   <= {stage[SYNC_STAGES-2:0], pinVec};
      sckPrev <= sckS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      rxWord   <= '0;
      byteDone <= 1'b0;
      byteIdx  <= '0;
      txShift  <= '0;
      sdo      <= 1'b0;
    end else if (rstSync) begin
      bitCnt   <= '0;
      rxWord   <= '0;
      byteDone <= 1'b0;
      byteIdx  <= '0;
      txShift  <= '0;
      sdo      <= 1'b0;
    end else begin
      byteDone <= rise && (bitCnt[2:0] == 3'd7);
      if (rise) begin
        rxWord <= {rxWord[INSTR_BITS-2:0], sdiS};
        bitCnt <= bitCnt + CW'(1);
        if (bitCnt[2:0] == 3'd7) byteIdx <= bitCnt[CW-1:3];
      end
      if (ctrl.txLoad) begin
        txShift <= ctrl.txByte;
      end else if (fall) begin
        sdo     <= txShift[7];
        txShift <= {txShift[6:0], 1'b0};
      end
    end
  end

  // R8, R3: the serial output moves only on a falling serial clock or a pin reset
  a_r8_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdo) |-> ($past(fall) || $past(rstSync)));
  // R10: a pin reset suppresses the byte completion of the same cycle
  a_r10_reset_beats_byte: assert property (@(posedge clk) disable iff (!rstN)
    rstSync |=> !byteDone);
  // R9: after a pin reset the output is quiet
  a_r9_reset_quiets_sdo: assert property (@(posedge clk) disable iff (!rstN)
    rstSync |=> !sdo);
endmodule

// File: rtl/isp_control.sv
module isp_control
  import isp_pkg::*;
#(
  parameter int SLOT_BITS = 7
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rstSync,
  input  logic                  byteDone,
  input  logic [1:0]            byteIdx,
  input  logic [INSTR_BITS-1:0] rxWord,
  input  logic [7:0]            readData,
  output ctrlStrobes_t          ctrl,
  output logic                  progEnabled,
  output logic                  instrValid,
  output logic [7:0]            instrOpcode,
  output logic [15:0]           instrAddr,
  output logic [7:0]            instrData,
  output logic                  pageWrEn,
  output logic [SLOT_BITS-1:0]  pageSlot,
  output logic                  pageHigh
);
  logic [7:0] op, b2, b3, b4;
  logic lastByte, isEnable, accept, isLoad;

  assign op = rxWord[31:24];
  assign b2 = rxWord[23:16];
  assign b3 = rxWord[15:8];
  assign b4 = rxWord[7:0];
  assign lastByte = byteDone && (byteIdx == 2'd3);
  assign isEnable = (op == OP_PREFIX) && (b2 == KEY_ENABLE);
  assign accept   = isEnable || progEnabled;
  assign isLoad   = (op == OP_LOAD_LO) || (op == OP_LOAD_HI);

  always_comb begin
    ctrl.txLoad = 1'b0;
    ctrl.txByte = readData;
    if (byteDone && byteIdx == 2'd1 && rxWord[15:8] == OP_PREFIX) begin
      ctrl.txLoad = 1'b1;
      ctrl.txByte = rxWord[7:0];
    end else if (byteDone && byteIdx == 2'd2 && progEnabled && isReadOp(rxWord[23:16])) begin
      ctrl.txLoad = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progEnabled <= 1'b0;
      instrValid  <= 1'b0;
      instrOpcode <= '0;
      instrAddr   <= '0;
      instrData   <= '0;
      pageWrEn    <= 1'b0;
      pageSlot    <= '0;
      pageHigh    <= 1'b0;
    end else if (rstSync) begin
      progEnabled <= 1'b0;
      instrValid  <= 1'b0;
      pageWrEn    <= 1'b0;
    end else begin
      instrValid <= lastByte && accept;
      pageWrEn   <= lastByte && progEnabled && isLoad;
      if (lastByte && accept) begin
        instrOpcode <= op;
        instrAddr   <= {b2, b3};
        instrData   <= b4;
        pageSlot    <= b3[SLOT_BITS-1:0];
        pageHigh    <= op[3];
      end
      if (lastByte && isEnable) progEnabled <= 1'b1;
    end
  end

  // R2: a strobe follows only the completion of the fourth byte
  a_r2_strobe_after_last_byte: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |-> $past(byteDone && byteIdx == 2'd3));
  // R4: enabling coincides with a strobed enable instruction
  a_r4_enable_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progEnabled) |-> (instrValid && instrOpcode == OP_PREFIX && instrAddr[15:8] == KEY_ENABLE));
  // R5: page writes need a prior enable
  a_r5_page_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    pageWrEn |-> ($past(progEnabled) && instrValid));
  // R9: a pin reset drops the enable and any strobe
  a_r9_reset_drops_enable: assert property (@(posedge clk) disable iff (!rstN)
    rstSync |=> (!progEnabled && !instrValid && !pageWrEn));
endmodule

// File: rtl/prog_serial_target.sv
module prog_serial_target
  import isp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SLOT_BITS   = 7
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sckPin,
  input  logic                 sdiPin,
  input  logic                 progResetPin,
  input  logic [7:0]           readData,
  output logic                 sdoPin,
  output logic                 progEnabled,
  output logic                 instrValid,
  output logic [7:0]           instrOpcode,
  output logic [15:0]          instrAddr,
  output logic [7:0]           instrData,
  output logic [15:0]          rdAddr,
  output logic                 pageWrEn,
  output logic [SLOT_BITS-1:0] pageSlot,
  output logic                 pageHigh
);
  ctrlStrobes_t ctrl;
  logic rstSync, byteDone;
  logic [1:0] byteIdx;
  logic [INSTR_BITS-1:0] rxWord;

  assign rdAddr = rxWord[15:0];

  isp_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .sdiPin(sdiPin),
    .progResetPin(progResetPin), .ctrl(ctrl), .sdo(sdoPin),
    .rstSync(rstSync), .byteDone(byteDone), .byteIdx(byteIdx), .rxWord(rxWord)
  );

  isp_control #(.SLOT_BITS(SLOT_BITS)) u_ctl (
    .clk(clk), .rstN(rstN), .rstSync(rstSync), .byteDone(byteDone),
    .byteIdx(byteIdx), .rxWord(rxWord), .readData(readData), .ctrl(ctrl),
    .progEnabled(progEnabled), .instrValid(instrValid), .instrOpcode(instrOpcode),
    .instrAddr(instrAddr), .instrData(instrData), .pageWrEn(pageWrEn),
    .pageSlot(pageSlot), .pageHigh(pageHigh)
  );
endmodule

// File: tb/prog_serial_target_test.sv
module prog_serial_target_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN, sckPin, sdiPin, progResetPin;
  logic [7:0] readData;
  logic sdoPin, progEnabled, instrValid, pageWrEn, pageHigh;
  logic [7:0] instrOpcode, instrData;
  logic [15:0] instrAddr, rdAddr;
  logic [6:0] pageSlot;

  always #2 clk = ~clk;

  prog_serial_target uut (
    .clk(clk), .rstN(rstN), .sckPin(sckPin), .sdiPin(sdiPin),
    .progResetPin(progResetPin), .readData(readData), .sdoPin(sdoPin),
    .progEnabled(progEnabled), .instrValid(instrValid), .instrOpcode(instrOpcode),
    .instrAddr(instrAddr), .instrData(instrData), .rdAddr(rdAddr),
    .pageWrEn(pageWrEn), .pageSlot(pageSlot), .pageHigh(pageHigh)
  );

  typedef struct {
    logic [7:0]  op;
    logic [15:0] addr;
    logic [7:0]  data;
    logic        page;
    logic [6:0]  slot;
    logic        hi;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  logic expEnabled = 1'b0;
  logic [7:0] mem [16];

  assign readData = mem[rdAddr[3:0]];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected strobes, and the memory model reacts to erase
  always @(negedge clk) begin
    if (instrValid) begin
      if (expQ.size() == 0) begin
        chk("R5 unexpected strobe", {instrOpcode, instrAddr, instrData}, 32'h0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        chk("R2 strobe fields", {instrOpcode, instrAddr, instrData}, {it.op, it.addr, it.data});
        chk("R6 page write flag", {31'h0, pageWrEn}, {31'h0, it.page});
        if (it.page) chk("R6 slot and half", {24'h0, pageHigh, pageSlot}, {24'h0, it.hi, it.slot});
        if (instrOpcode == 8'hAC && instrAddr[15:8] == 8'h80)
          for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
      end
    end else if (pageWrEn) begin
      chk("R6 page write without strobe", 32'h1, 32'h0);
    end
  end

  task automatic shiftBit(input logic b, output logic r);
    @(negedge clk);
    sdiPin = b;
    sckPin = 1'b0;
    repeat (HALF) @(negedge clk);
    r = sdoPin;
    sckPin = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] w, output logic [31:0] r);
    logic bit1;
    for (int i = 31; i >= 0; i--) begin
      shiftBit(w[i], bit1);
      r[i] = bit1;
    end
    repeat (HALF) @(negedge clk);
  endtask

  // driver: predicts the strobe from the requirements and queues it
  task automatic sendInstr(input logic [31:0] w, output logic [31:0] r);
    item_t it;
    logic isEn, isLd;
    isEn = (w[31:24] == 8'hAC) && (w[23:16] == 8'h53);
    isLd = (w[31:24] == 8'h40) || (w[31:24] == 8'h48);
    if (isEn || expEnabled) begin
      it.op = w[31:24]; it.addr = w[23:8]; it.data = w[7:0];
      it.page = expEnabled && isLd; it.slot = w[14:8]; it.hi = w[27];
      expQ.push_back(it);
    end
    xfer(w, r);
    if (isEn) expEnabled = 1'b1;
  endtask

  task automatic pinReset();
    @(negedge clk);
    progResetPin = 1'b1;
    repeat (HALF) @(negedge clk);
    progResetPin = 1'b0;
    repeat (HALF) @(negedge clk);
    expEnabled = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    logic bt;
    for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i);
    rstN = 1'b0; sckPin = 1'b0; sdiPin = 1'b0; progResetPin = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 reset outputs", {28'h0, sdoPin, progEnabled, instrValid, pageWrEn}, 32'h0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // R5: gated before enable
    sendInstr(32'h4000_05AA, r);
    chk("R5 no return before enable", r, 32'h0);
    sendInstr(32'h2000_0300, r);
    chk("R5 read silent before enable", r, 32'h0);
    chk("R5 still disabled", {31'h0, progEnabled}, 32'h0);

    // R9: offset stream is not recovered until a pin reset
    for (int i = 0; i < 5; i++) shiftBit(1'b0, bt);
    xfer(32'hAC53_0000, r);
    chk("R9 misaligned enable rejected", {31'h0, progEnabled}, 32'h0);
    pinReset();

    // R4 and R3
    sendInstr(32'hAC53_0000, r);
    chk("R3 echo of second byte", {24'h0, r[15:8]}, 32'h53);
    chk("R8 quiet outside echo", {r[31:16], r[7:0]}, 32'h0);
    chk("R4 enabled", {31'h0, progEnabled}, 32'h1);

    // R6: page loads, including top slot and high half
    sendInstr(32'h4000_05AA, r);
    chk("R8 quiet during load", r, 32'h0);
    sendInstr(32'h4800_FF5B, r);
    sendInstr(32'h4012_00C3, r);

    // R7: reads
    sendInstr(32'h2000_0300, r);
    chk("R7 program read", {24'h0, r[7:0]}, 32'h13);
    chk("R8 quiet before read byte", {8'h0, r[31:8]}, 32'h0);
    sendInstr(32'hA000_0A00, r);
    chk("R7 eeprom read", {24'h0, r[7:0]}, 32'h1A);

    // R11: erase keeps enable, memory reads back erased
    sendInstr(32'hAC80_0000, r);
    chk("R3 echo of non-key byte", {24'h0, r[15:8]}, 32'h80);
    chk("R11 enable kept after erase", {31'h0, progEnabled}, 32'h1);
    sendInstr(32'h2800_0300, r);
    chk("R11 erased byte reads FF", {24'h0, r[7:0]}, 32'hFF);

    // R10: pin reset coincides with the final rising edge
    begin
      logic [31:0] w;
      w = 32'h4000_0177;
      for (int i = 31; i >= 1; i--) shiftBit(w[i], bt);
      @(negedge clk);
      sdiPin = w[0];
      sckPin = 1'b0;
      repeat (HALF) @(negedge clk);
      sckPin = 1'b1;
      progResetPin = 1'b1;
      repeat (HALF) @(negedge clk);
      progResetPin = 1'b0;
      repeat (HALF) @(negedge clk);
      expEnabled = 1'b0;
    end
    chk("R10 reset wins, disabled", {31'h0, progEnabled}, 32'h0);
    sendInstr(32'hAC53_0000, r);
    chk("R9 framing recovered", {31'h0, progEnabled}, 32'h1);
    chk("R3 echo after recovery", {24'h0, r[15:8]}, 32'h53);

    repeat (4 * HALF) @(negedge clk);
    chk("R2 all expected strobes seen", expQ.size(), 32'h0);
    finishRun();
  end
endmodule